// File: doc/BRIEF.md
# Big-Endian 16-Bit Memory Bus Sequencer

This block connects a 32-bit internal datapath to an external memory that is byte addressable, organised as 16-bit words and reached through a 24-bit address. The datapath presents one request at a time through a valid/ready handshake. Each request carries a 32-bit address, an access size, a direction flag and up to 32 bits of write data. The sequencer then runs one external word cycle for a byte or a word, or two back-to-back word cycles for a long word. Each cycle uses a request/acknowledge pair toward memory and waits for the acknowledge. Data is placed on the correct half of the bus for big-endian byte order, and only the active bytes carry a strobe.

Read results come back right-aligned with a one-cycle response pulse. If a word or long access names an odd address, the block reports it with a one-cycle fault pulse and does not touch memory.

Top module: `be16_bus_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `mem_req`, `rsp_valid` and `addr_err` are 0.
- R2: The first bus cycle of an accepted request drives `mem_addr` with bits 23:0 of `req_addr`. Bits 31:24 have no effect on the bus.
- R3: Size codes are 0 = byte, 1 = word, and 2 or 3 = long. A byte at an even address asserts only `mem_be[1]` and carries the byte on `mem_wdata[15:8]`. A byte at an odd address asserts only `mem_be[0]` and uses `mem_wdata[7:0]`. Both halves of the byte on the other lane are zero. Word and long cycles assert `mem_be = 2'b11`.
- R4: A long access runs exactly two bus cycles. The first is at address A with write data bits 31:16. The second is at (A+2) modulo 2^24 with bits 15:0. Byte and word accesses run exactly one bus cycle.
- R5: A byte read returns the addressed lane in `rsp_rdata[7:0]`, and a word read returns the bus word in bits 15:0. In both cases the upper bits are zero. A long read returns {first word, second word}. A write returns zero.
- R6: A word or long request with address bit 0 set raises `addr_err` for exactly one cycle, directly after the accepting edge. It starts no bus cycle and gives no `rsp_valid`.
- R7: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_we`, `mem_be` and `mem_wdata` hold their values.
- R8: `rsp_valid` is a one-cycle pulse that appears in the cycle right after the edge at which the last acknowledge is sampled. `req_ready` is 0 while any bus cycle is outstanding.
- R9: A `req_valid` that arrives while `req_ready` is 0 is ignored. It starts no bus cycle and changes no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered by datapath |
| req_ready | output | 1 | Sequencer can accept a request |
| req_addr | input | 32 | Internal byte address |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Right-aligned read result |
| addr_err | output | 1 | One-cycle misalignment fault pulse |
| mem_req | output | 1 | External bus cycle request |
| mem_addr | output | 24 | External byte address |
| mem_we | output | 1 | External write enable |
| mem_be | output | 2 | Byte strobes, bit 1 = bits 15:8 |
| mem_wdata | output | 16 | External write data |
| mem_ack | input | 1 | Bus cycle acknowledge |
| mem_rdata | input | 16 | External read data, valid with ack |

## Verification
A fault is due in the first cycle after the edge that accepts the request. A response is due in the cycle right after the edge that samples the final acknowledge. A memory model adds a programmable wait of zero to four cycles before each acknowledge. It logs the address, strobes and data of every acknowledged beat and the cycle number of the edge that took it. The bench reads outputs only on falling edges and compares the cycle of each response pulse against that logged edge. It also compares the beat log against addresses, lanes and data computed from a byte-level big-endian reference.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_WORD     = 2'd1,
    SZ_LONG     = 2'd2,
    SZ_LONG_ALT = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUS   = 2'd1,
    ST_FAULT = 2'd2
  } seq_state_e;

  // Size codes with bit 1 set move two bus words.
  function automatic logic is_long(input logic [1:0] size);
    return size[1];
  endfunction

endpackage

// File: rtl/bseq_align_chk.sv
module bseq_align_chk #(
  parameter int OFF_W = 1
) (
  input  logic [1:0]       size,
  input  logic [OFF_W-1:0] byte_off,
  output logic             fault
);
  import bseq_pkg::*;

  // Anything wider than a byte must start on a bus-word boundary.
  assign fault = (size != SZ_BYTE) && (|byte_off);

endmodule

// File: rtl/bseq_lane_steer.sv
module bseq_lane_steer #(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 32,
  parameter int LANES  = BUS_W / 8,
  parameter int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic              second_beat,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [BUS_W-1:0]  lane_data
);
  import bseq_pkg::*;

  logic single;
  logic upper_half;

  assign single     = (size == SZ_BYTE);
  assign upper_half = is_long(size) && !second_beat;

  // Big-endian: byte offset 0 sits on the most significant lane.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int OFS = LANES - 1 - l;
    logic hit;
    assign hit = (byte_off == OFF_W'(OFS));
    assign be[l] = single ? hit : 1'b1;
    assign lane_data[l*8 +: 8] =
      single     ? (hit ? wdata[7:0] : 8'h00) :
      upper_half ? wdata[BUS_W + l*8 +: 8] :
                   wdata[l*8 +: 8];
  end

endmodule

// File: rtl/bseq_read_pack.sv
module bseq_read_pack #(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 32,
  parameter int LANES  = BUS_W / 8,
  parameter int OFF_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  byte_off,
  input  logic [BUS_W-1:0]  first_word,
  input  logic [BUS_W-1:0]  last_word,
  output logic [DATA_W-1:0] rdata
);
  import bseq_pkg::*;

  logic [7:0] picked;

  always_comb begin
    picked = last_word[(LANES - 1 - int'(byte_off)) * 8 +: 8];
    rdata  = '0;
    if (size == SZ_BYTE) begin
      rdata[7:0] = picked;
    end else if (is_long(size)) begin
      rdata[DATA_W-1 -: BUS_W] = first_word;
      rdata[BUS_W-1:0]         = last_word;
    end else begin
      rdata[BUS_W-1:0] = last_word;
    end
  end

endmodule

// File: rtl/be16_bus_seq.sv
module be16_bus_seq #(
  parameter int ADDR_W = 32,
  parameter int EXT_AW = 24,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              addr_err,
  output logic              mem_req,
  output logic [EXT_AW-1:0] mem_addr,
  output logic              mem_we,
  output logic [BUS_W/8-1:0] mem_be,
  output logic [BUS_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [BUS_W-1:0]  mem_rdata
);
  import bseq_pkg::*;

  localparam int LANES = BUS_W / 8;
  localparam int OFF_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [EXT_AW-1:0] BEAT_STEP = EXT_AW'(LANES);

  seq_state_e        state;
  logic [1:0]        size_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              beat1_q;
  logic [BUS_W-1:0]  first_q;

  logic              take;
  logic              fault_now;
  logic              idle;
  logic [1:0]        st_size;
  logic [OFF_W-1:0]  st_off;
  logic [DATA_W-1:0] st_wdata;
  logic [LANES-1:0]  st_be;
  logic [BUS_W-1:0]  st_data;
  logic [DATA_W-1:0] packed_rd;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^req_addr[ADDR_W-1:EXT_AW];

  assign idle     = (state == ST_IDLE);
  assign take     = idle && req_valid && req_ready;
  assign st_size  = idle ? req_size : size_q;
  assign st_off   = idle ? req_addr[OFF_W-1:0] : off_q;
  assign st_wdata = idle ? req_wdata : wdata_q;

  bseq_align_chk #(.OFF_W(OFF_W)) align_i (
    .size     (req_size),
    .byte_off (req_addr[OFF_W-1:0]),
    .fault    (fault_now)
  );

  bseq_lane_steer #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)
  ) steer_i (
    .size        (st_size),
    .byte_off    (st_off),
    .second_beat (!idle),
    .wdata       (st_wdata),
    .be          (st_be),
    .lane_data   (st_data)
  );

  bseq_read_pack #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)
  ) pack_i (
    .size       (size_q),
    .byte_off   (off_q),
    .first_word (first_q),
    .last_word  (mem_rdata),
    .rdata      (packed_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      addr_err  <= 1'b0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_be    <= '0;
      mem_wdata <= '0;
      size_q    <= SZ_BYTE;
      off_q     <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      beat1_q   <= 1'b0;
      first_q   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      addr_err  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            req_ready <= 1'b0;
            if (fault_now) begin
              addr_err <= 1'b1;
              state    <= ST_FAULT;
            end else begin
              mem_req   <= 1'b1;
              mem_addr  <= req_addr[EXT_AW-1:0];
              mem_we    <= req_write;
              mem_be    <= st_be;
              mem_wdata <= st_data;
              size_q    <= req_size;
              off_q     <= req_addr[OFF_W-1:0];
              wdata_q   <= req_wdata;
              we_q      <= req_write;
              beat1_q   <= 1'b0;
              state     <= ST_BUS;
            end
          end
        end
        ST_BUS: begin
          if (mem_ack) begin
            if (is_long(size_q) && !beat1_q) begin
              first_q   <= mem_rdata;
              beat1_q   <= 1'b1;
              mem_addr  <= mem_addr + BEAT_STEP;
              mem_be    <= st_be;
              mem_wdata <= st_data;
            end else begin
              mem_req   <= 1'b0;
              mem_we    <= 1'b0;
              mem_be    <= '0;
              mem_wdata <= '0;
              rsp_valid <= 1'b1;
              rsp_rdata <= we_q ? '0 : packed_rd;
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end
          end
        end
        ST_FAULT: begin
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/be16_bus_seq_chk.sv
module be16_bus_seq_chk #(
  parameter int EXT_AW = 24,
  parameter int BUS_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               addr_err,
  input logic               mem_req,
  input logic [EXT_AW-1:0]  mem_addr,
  input logic               mem_we,
  input logic [BUS_W/8-1:0] mem_be,
  input logic [BUS_W-1:0]   mem_wdata,
  input logic               mem_ack
);

  // R7
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_be) && $stable(mem_wdata)));

  // R6
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (!mem_req && !rsp_valid));

  // R6
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    addr_err |=> !addr_err);

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  // R3
  strobe_live_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be != '0));

endmodule

bind be16_bus_seq be16_bus_seq_chk #(.EXT_AW(EXT_AW), .BUS_W(BUS_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .addr_err  (addr_err),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/be16_bus_seq_tb_top.sv
`timescale 1ns/1ps
module be16_bus_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        addr_err;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_we;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic        mem_ack;
  logic [15:0] mem_rdata;

  always #2 clk = ~clk;

  be16_bus_seq dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .addr_err(addr_err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model with beat log ----------------
  logic [15:0] ram [256];
  int          wait_cfg = 0;
  int          wcnt;
  int          cyc = 0;
  int          ack_total;
  int          last_ack_cyc;
  logic [23:0] log_addr  [64];
  logic [1:0]  log_be    [64];
  logic [15:0] log_wdata [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_ack      <= 1'b0;
      mem_rdata    <= '0;
      wcnt         <= 0;
      ack_total    <= 0;
      last_ack_cyc <= -1;
      for (int i = 0; i < 256; i++) ram[i] <= '0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (wcnt >= wait_cfg) begin
          mem_ack   <= 1'b1;
          mem_rdata <= ram[mem_addr[8:1]];
          wcnt      <= 0;
        end else begin
          wcnt <= wcnt + 1;
        end
      end else begin
        mem_ack <= 1'b0;
      end
      if (mem_req && mem_ack) begin
        if (mem_we && mem_be[1]) ram[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
        if (mem_we && mem_be[0]) ram[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
        log_addr[ack_total % 64]  <= mem_addr;
        log_be[ack_total % 64]    <= mem_be;
        log_wdata[ack_total % 64] <= mem_wdata;
        ack_total    <= ack_total + 1;
        last_ack_cyc <= cyc + 1;
      end
    end
  end

  // ---------------- hold monitor ----------------
  int          stab_bad = 0;
  int          stab_seen = 0;
  logic        hold_prev = 1'b0;
  logic [44:0] snap_prev = '0;

  always @(negedge clk) begin
    if (!rst && hold_prev) begin
      stab_seen++;
      if (!mem_req || {mem_addr, mem_we, mem_be, mem_wdata, 2'b00} != snap_prev)
        stab_bad++;
    end
    hold_prev = !rst && mem_req && !mem_ack;
    snap_prev = {mem_addr, mem_we, mem_be, mem_wdata, 2'b00};
  end

  // ---------------- checking helpers ----------------
  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // big-endian byte reference, 512 bytes
  logic [7:0] ref_mem [512];

  function automatic logic [8:0] bi(input logic [31:0] a, input int k);
    logic [23:0] s;
    s = a[23:0] + 24'(k);
    return s[8:0];
  endfunction

  task automatic ref_write(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    if (sz == 2'd0) ref_mem[bi(a, 0)] = d[7:0];
    else if (sz == 2'd1) begin
      ref_mem[bi(a, 0)] = d[15:8]; ref_mem[bi(a, 1)] = d[7:0];
    end else begin
      ref_mem[bi(a, 0)] = d[31:24]; ref_mem[bi(a, 1)] = d[23:16];
      ref_mem[bi(a, 2)] = d[15:8];  ref_mem[bi(a, 3)] = d[7:0];
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [1:0] sz, input logic [31:0] a);
    if (sz == 2'd0) return {24'h0, ref_mem[bi(a, 0)]};
    if (sz == 2'd1) return {16'h0, ref_mem[bi(a, 0)], ref_mem[bi(a, 1)]};
    return {ref_mem[bi(a, 0)], ref_mem[bi(a, 1)], ref_mem[bi(a, 2)], ref_mem[bi(a, 3)]};
  endfunction

  task automatic run_req(input logic w, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] d, input int wt,
                         output logic got_err, output logic [31:0] got_data,
                         output int beats, output logic lat_ok, output int start);
    logic fin;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wait_cfg  = wt;
    start     = ack_total;
    req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    got_err = 1'b0; got_data = '0; lat_ok = 1'b0; fin = 1'b0;
    for (int k = 0; k < 80 && !fin; k++) begin
      if (addr_err) begin
        got_err = 1'b1; lat_ok = (k == 0); fin = 1'b1;
      end else if (rsp_valid) begin
        got_data = rsp_rdata; lat_ok = (cyc == last_ack_cyc); fin = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    beats = ack_total - start;
  endtask

  // ---------------- vector table: {write, size, addr, data} ----------------
  localparam int NV = 16;
  localparam logic [66:0] VECS [NV] = '{
    {1'b1, 2'd2, 32'h0000_0010, 32'h1122_3344},
    {1'b0, 2'd2, 32'h0000_0010, 32'h0},
    {1'b0, 2'd1, 32'h0000_0012, 32'h0},
    {1'b0, 2'd0, 32'h0000_0010, 32'h0},
    {1'b0, 2'd0, 32'h0000_0013, 32'h0},
    {1'b1, 2'd0, 32'h0000_0015, 32'h0000_00AB},
    {1'b1, 2'd0, 32'h0000_0014, 32'h0000_00CD},
    {1'b0, 2'd1, 32'h0000_0014, 32'h0},
    {1'b1, 2'd1, 32'hFF00_0020, 32'h0000_BEEF},
    {1'b0, 2'd2, 32'h0000_0020, 32'h0},
    {1'b1, 2'd1, 32'h0000_0021, 32'h0000_5555},
    {1'b0, 2'd2, 32'h0000_0013, 32'h0},
    {1'b1, 2'd2, 32'h00FF_FFFE, 32'hCAFE_F00D},
    {1'b0, 2'd1, 32'h0000_0000, 32'h0},
    {1'b0, 2'd3, 32'h0000_0010, 32'h0},
    {1'b0, 2'd1, 32'h0000_0020, 32'h0}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic        ge;
    logic [31:0] gd;
    int          nb;
    logic        lo;
    int          st;
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;

    // R1: reset state, during and just after reset
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", {31'h0, req_ready}, 32'h1);
    chk("R1", "mem_req/rsp/err in reset", {29'h0, mem_req, rsp_valid, addr_err}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "ready after reset", {31'h0, req_ready}, 32'h1);
    chk("R1", "mem_req/rsp/err after reset", {29'h0, mem_req, rsp_valid, addr_err}, 32'h0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic        w;
      logic [1:0]  sz;
      logic [31:0] a, d, exp_d;
      logic        exp_err, lng;
      int          exp_beats;
      logic [1:0]  exp_be;
      logic [15:0] exp_w0, exp_w1;
      w  = VECS[v][66]; sz = VECS[v][65:64]; a = VECS[v][63:32]; d = VECS[v][31:0];
      lng       = sz[1];
      exp_err   = (sz != 2'd0) && a[0];
      exp_beats = exp_err ? 0 : (lng ? 2 : 1);
      exp_d     = w ? 32'h0 : ref_read(sz, a);
      exp_be    = (sz == 2'd0) ? (a[0] ? 2'b01 : 2'b10) : 2'b11;
      exp_w0    = (sz == 2'd0) ? (a[0] ? {8'h00, d[7:0]} : {d[7:0], 8'h00})
                               : (lng ? d[31:16] : d[15:0]);
      exp_w1    = d[15:0];
      run_req(w, sz, a, d, v % 5, ge, gd, nb, lo, st);
      chk("R6", $sformatf("vec %0d fault flag", v), {31'h0, ge}, {31'h0, exp_err});
      chk("R4", $sformatf("vec %0d beat count", v), nb, exp_beats);
      if (exp_err) begin
        chk("R6", $sformatf("vec %0d fault timing", v), {31'h0, lo}, 32'h1);
      end else begin
        chk("R8", $sformatf("vec %0d response timing", v), {31'h0, lo}, 32'h1);
        chk("R5", $sformatf("vec %0d read data", v), gd, exp_d);
        chk("R2", $sformatf("vec %0d first address", v), {8'h0, log_addr[st % 64]}, {8'h0, a[23:0]});
        chk("R3", $sformatf("vec %0d first strobes", v), {30'h0, log_be[st % 64]}, {30'h0, exp_be});
        if (w) chk("R3", $sformatf("vec %0d first lane data", v), {16'h0, log_wdata[st % 64]}, {16'h0, exp_w0});
        if (lng) begin
          chk("R4", $sformatf("vec %0d second address", v),
              {8'h0, log_addr[(st + 1) % 64]}, {8'h0, a[23:0] + 24'd2});
          if (w) chk("R4", $sformatf("vec %0d second data", v),
                     {16'h0, log_wdata[(st + 1) % 64]}, {16'h0, exp_w1});
        end
        if (w) ref_write(sz, a, d);
      end
    end

    // R9: request offered while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    wait_cfg = 4; st = ack_total;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 32'h10; req_wdata = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 32'h30; req_wdata = 32'h5A;
    chk("R9", "ready low while busy", {31'h0, req_ready}, 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 40 && !rsp_valid; k++) @(negedge clk);
    chk("R9", "long read unaffected", rsp_rdata, ref_read(2'd2, 32'h10));
    chk("R9", "beats for busy window", ack_total - st, 2);
    run_req(1'b0, 2'd0, 32'h30, 32'h0, 0, ge, gd, nb, lo, st);
    chk("R9", "ignored byte not written", gd, 32'h0);

    // R7: bus outputs held across wait states
    chk("R7", "hold samples seen", {31'h0, stab_seen > 0}, 32'h1);
    chk("R7", "hold violations", stab_bad, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule